// File: doc/BRIEF.md
# Data Pin Drive Sequencer

This block sits between a pipelined synchronous memory core and its shared bidirectional data and parity pins. On each accepted clock edge it looks at the access the core has just accepted. That access is a read, a write, or a deselect. The block then decides whether the memory may drive the pins during that access's data beat. The drive-enable output is the AND of two terms. One is an asynchronous active-low output-enable pin. The other is a registered internal mask. The block also holds the output data register, which carries the read word to the pads.

The mask is set only for the data beat of a read. It is clear for these beats:
- the data beat of a write, so that external logic can present write data;
- the beat after a deselecting edge, because deselect is pipelined by one accepted edge;
- the first beat after the device leaves the deselected state;
- the time after reset.

A high clock-enable input stalls the block. During a stall every flop keeps its value, so the drive state and the output word stay as they are. The pad cells are outside the block. Only the enable and the data word leave it.

Top module: `odrv_seq`

## Requirements
- R1: While reset is asserted, and after its release until a read data beat, `driveEn` is 0 and `rdOut` is all zeros, whatever the level of `oeN`.
- R2: Suppose a read (`accSel`=1, `accWrite`=0) is accepted at one edge with `clkEnN`=0. After the next accepted edge, `driveEn` equals the inverse of `oeN`. At that same edge, `rdOut` loads the `coreRdData` value present there.
- R3: `oeN` high forces `driveEn` to 0 in the same cycle, with no clock edge needed. `oeN` low lets the registered mask through in the same cycle.
- R4: Suppose a write (`accSel`=1, `accWrite`=1) is accepted. After the next accepted edge, `driveEn` is 0 even with `oeN` low.
- R5: Suppose a deselect (`accSel`=0) is accepted. The beat already under way, such as the data beat of an earlier read, keeps its drive until the next accepted edge. After that edge, `driveEn` is 0.
- R6: Suppose the block leaves the deselected state with a read. In the cycle right after the selecting edge, `driveEn` stays 0 even with `oeN` low.
- R7: An edge with `clkEnN`=1 is ignored. Across that edge, `driveEn` (with `oeN` held) and `rdOut` keep their values, and the command inputs presented at it have no effect.
- R8: Reads and writes accepted on consecutive edges give data beats with no gap between them. For read, write, read, each beat drives or floats as its own command requires.
- R9: `rdOut` changes only at the edge that opens a read data beat. A write data beat leaves `rdOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high stalls the block |
| accSel | input | 1 | Core accepted a selected access this cycle |
| accWrite | input | 1 | Accepted access is a write (meaningful when accSel=1) |
| coreRdData | input | DATA_W | Read word from the memory core, valid at the edge that opens the read beat |
| oeN | input | 1 | Asynchronous output enable, active low |
| driveEn | output | 1 | Pad drive enable for data and parity pins |
| rdOut | output | DATA_W | Output data register contents |

## Verification
Every registered result is due one accepted edge after the edge that accepted its command. The one exception is the output-enable gate, which acts within the same cycle. The bench applies stimulus on the falling edge and takes one rising edge. It then checks on the next falling edge, so each check reads the state left by exactly one edge. Stalled edges are counted as taking no step, and the bench checks that the outputs held across them. The `oeN` checks are made a nanosecond after the pin toggles, with no clock edge in between.

// File: rtl/odrv_seq_pkg.sv
package odrv_seq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // accepted edge
    logic loadRead;  // edge opening a read data beat
  } seqStrobe_t;

endpackage

// File: rtl/odrv_seq_ctrl.sv
module odrv_seq_ctrl
  import odrv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEnN,
  input  logic       accSel,
  input  logic       accWrite,
  output seqStrobe_t strobe,
  output logic       maskQ
);

  // command captured at the previous accepted edge
  logic cmdSelQ;
  logic cmdWrQ;
  logic advance;
  logic readBeatNext;

  assign advance      = ~clkEnN;
  assign readBeatNext = cmdSelQ & ~cmdWrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSelQ <= 1'b0;
      cmdWrQ  <= 1'b0;
      maskQ   <= 1'b0;
    end else if (advance) begin
      cmdSelQ <= accSel;
      cmdWrQ  <= accSel & accWrite;
      // data beat of the previously accepted command
      maskQ   <= readBeatNext;
    end
  end

  always_comb begin
    strobe.advance  = advance;
    strobe.loadRead = advance & readBeatNext;
  end

endmodule

// File: rtl/odrv_seq_dpath.sv
module odrv_seq_dpath
  import odrv_seq_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] coreRdData,
  output logic [DATA_W-1:0] rdOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOut <= '0;
    end else if (strobe.loadRead) begin
      rdOut <= coreRdData;
    end
  end

endmodule

// File: rtl/odrv_seq.sv
module odrv_seq
  import odrv_seq_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              accSel,
  input  logic              accWrite,
  input  logic [DATA_W-1:0] coreRdData,
  input  logic              oeN,
  output logic              driveEn,
  output logic [DATA_W-1:0] rdOut
);

  seqStrobe_t strobe;
  logic       maskQ;

  odrv_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEnN   (clkEnN),
    .accSel   (accSel),
    .accWrite (accWrite),
    .strobe   (strobe),
    .maskQ    (maskQ)
  );

  odrv_seq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .coreRdData (coreRdData),
    .rdOut      (rdOut)
  );

  // only the output-enable term is combinational
  assign driveEn = ~oeN & maskQ;

endmodule

// File: rtl/odrv_seq_chk.sv
module odrv_seq_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              accSel,
  input logic              accWrite,
  input logic              oeN,
  input logic              driveEn,
  input logic [DATA_W-1:0] rdOut
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!driveEn && rdOut == '0)); // R1

  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && accSel && !accWrite) ##1 !clkEnN |=> (driveEn == !oeN)); // R2

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !driveEn); // R3

  AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && accSel && accWrite) ##1 !clkEnN |=> !driveEn); // R4

  AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !accSel) ##1 !clkEnN |=> !driveEn); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(rdOut)); // R7

endmodule

bind odrv_seq odrv_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEnN   (clkEnN),
  .accSel   (accSel),
  .accWrite (accWrite),
  .oeN      (oeN),
  .driveEn  (driveEn),
  .rdOut    (rdOut)
);

// File: tb/odrv_seq_tb.sv
module odrv_seq_tb;

  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkEnN = 1'b0;
  logic          accSel = 1'b0;
  logic          accWrite = 1'b0;
  logic [DW-1:0] coreRdData = '0;
  logic          oeN = 1'b0;
  logic          driveEn;
  logic [DW-1:0] rdOut;
  wire  [DW-1:0] pinBus;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  odrv_seq #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .accSel(accSel),
    .accWrite(accWrite), .coreRdData(coreRdData), .oeN(oeN),
    .driveEn(driveEn), .rdOut(rdOut)
  );

  // pad model
  assign pinBus = driveEn ? rdOut : 'z;

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // apply inputs just after a falling edge, take one rising edge, return at next falling edge
  task automatic cyc(input logic cen, input logic sel, input logic wr, input logic [DW-1:0] d);
    clkEnN = cen; accSel = sel; accWrite = wr; coreRdData = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle2();
    cyc(1'b0, 1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_reset();
    oeN = 1'b0;
    @(negedge clk);
    chk("R1 driveEn in reset", {35'b0, driveEn}, '0);
    rstN = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 36'hF_FFFF_FFFF);
    chk("R1 driveEn after reset", {35'b0, driveEn}, '0);
    chk("R1 rdOut after reset", rdOut, '0);
  endtask

  task automatic t_read();
    idle2();
    cyc(1'b0, 1'b1, 1'b0, 36'h0_0000_0000);           // read accepted after deselect
    chk("R6 first beat after deselect", {35'b0, driveEn}, '0);
    cyc(1'b0, 1'b0, 1'b0, 36'hA_1234_5678);           // deselect; read beat opens
    chk("R2 read drive", {35'b0, driveEn}, 36'd1);
    chk("R2 read data", rdOut, 36'hA_1234_5678);
    chk("R2 pin bus", pinBus, 36'hA_1234_5678);
    oeN = 1'b1; #1;
    chk("R3 oeN high floats", {35'b0, driveEn}, '0);
    oeN = 1'b0; #1;
    chk("R3 oeN low drives", {35'b0, driveEn}, 36'd1);
    @(negedge clk);                                    // hold inputs, one more accepted edge
    chk("R5 pipelined deselect", {35'b0, driveEn}, '0);
  endtask

  task automatic t_write();
    idle2();
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b1, 36'h5_5555_AAAA);           // read beat, write accepted
    chk("R9 read data before write", rdOut, 36'h5_5555_AAAA);
    cyc(1'b0, 1'b0, 1'b0, 36'h0_DEAD_BEEF);           // write data beat
    chk("R4 write beat float", {35'b0, driveEn}, '0);
    chk("R9 write beat keeps rdOut", rdOut, 36'h5_5555_AAAA);
  endtask

  task automatic t_stall();
    idle2();
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, 36'h1_1111_2222);           // beat of first read
    cyc(1'b1, 1'b0, 1'b0, 36'h9_9999_9999);           // stall with deselect on inputs
    chk("R7 stall keeps drive", {35'b0, driveEn}, 36'd1);
    chk("R7 stall keeps data", rdOut, 36'h1_1111_2222);
    cyc(1'b1, 1'b1, 1'b1, 36'h8_8888_8888);           // stall with write on inputs
    chk("R7 second stall keeps data", rdOut, 36'h1_1111_2222);
    cyc(1'b0, 1'b0, 1'b0, 36'h3_3333_4444);           // beat of second read
    chk("R7 resume read drive", {35'b0, driveEn}, 36'd1);
    chk("R7 resume read data", rdOut, 36'h3_3333_4444);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk("R5 off after resume", {35'b0, driveEn}, '0);
  endtask

  task automatic t_b2b();
    idle2();
    cyc(1'b0, 1'b1, 1'b0, '0);                        // read A
    cyc(1'b0, 1'b1, 1'b1, 36'hA_AAAA_0001);           // write B; beat A
    chk("R8 beat A drive", {35'b0, driveEn}, 36'd1);
    chk("R8 beat A data", rdOut, 36'hA_AAAA_0001);
    cyc(1'b0, 1'b1, 1'b0, 36'hB_BBBB_0002);           // read C; beat B
    chk("R8 beat B float", {35'b0, driveEn}, '0);
    chk("R9 beat B holds data", rdOut, 36'hA_AAAA_0001);
    cyc(1'b0, 1'b0, 1'b0, 36'hC_CCCC_0003);           // deselect; beat C
    chk("R8 beat C drive", {35'b0, driveEn}, 36'd1);
    chk("R8 beat C data", rdOut, 36'hC_CCCC_0003);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk("R5 beat after deselect", {35'b0, driveEn}, '0);
  endtask

  initial begin
    t_reset();
    t_read();
    t_write();
    t_stall();
    t_b2b();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule